// File: doc/BRIEF.md
# Dual-Register Toggle DAC Register Bank

This block holds the digital input state of a 32-channel, 14-bit converter. Every channel owns two data registers, called A and B, and one output code register that feeds the converter. Decoded write transactions fill the data registers and a small control register. An active-low load strobe copies data into the output codes. Groups of eight channels can be put into toggle mode. In that mode successive strobes alternate the output between A and B, so each channel produces a square wave at the strobe rate.

The strobe is synchronised with two flip-flops and passed to a three-state pulse machine: `L_IDLE` goes to `L_FIRE` when the synchronised strobe is low. `L_FIRE` goes to `L_HOLD` while the strobe stays low and to `L_IDLE` once it is high. `L_HOLD` goes to `L_IDLE` when the strobe returns high. Only `L_FIRE` issues a load event.

Each group of eight channels has a phase machine with four states. `PH_OFF` means toggling is disabled. `PH_ARMED` means toggling is enabled and the next load takes A. `PH_SHOW_A` means A was loaded last. `PH_SHOW_B` means B was loaded last. The transitions are:
- disable, from any state, goes to `PH_OFF`;
- enable goes from `PH_OFF` to `PH_ARMED`;
- a load event moves `PH_ARMED` to `PH_SHOW_A`, `PH_SHOW_A` to `PH_SHOW_B`, and `PH_SHOW_B` to `PH_SHOW_A`.

Top module: `dtog_bank`

## Requirements
- R1: After reset every output code is 0, every phase flag shows A (0), every data register is 0 and toggling is disabled for all groups.
- R2: A write with `wr_sel` = 2'b11 stores `wr_data` into the A register of channel `wr_addr`.
- R3: A write with `wr_sel` = 2'b00 and `wr_addr` = 12 is a control write. Data bit 2 enables toggling for channels 0-7, bit 3 for 8-15, bit 4 for 16-23 and bit 5 for 24-31. The control write changes no data register.
- R4: A write with `wr_sel` = 2'b10 stores into the B register of channel `wr_addr` only if that channel's group currently has toggling enabled. Otherwise the write is ignored.
- R5: In a group with toggling enabled, the first load event after enabling copies A to the output and clears the flag. Each later event alternates B (flag 1) and A (flag 0).
- R6: Output codes and flags change only on a load event. The output changes on the fourth rising edge, counting the first edge that samples `ldac_n` low as the first. One low pulse gives exactly one event, whatever its length.
- R7: A group with toggling disabled loads A with flag 0 on every event. This includes the first event after toggling is switched off.
- R8: A write with `wr_sel` = 2'b01, or with `wr_sel` = 2'b00 and an address other than 12, changes nothing.
- R9: A data write in the same cycle as a load event takes effect after the load, so the output receives the old register value. A control write in that cycle takes effect after the load, so the event uses the old toggle mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write transaction valid |
| wr_sel | input | 2 | Register select |
| wr_addr | input | 5 | Channel address |
| wr_data | input | 14 | Write data |
| ldac_n | input | 1 | Asynchronous active-low load strobe |
| dac_code | output | 448 | Output codes, channel n at bits [14n+13:14n] |
| dac_sel_b | output | 32 | Per-channel flag, 1 when output came from B |

## Verification
Two functions can meet in one cycle. A register write or control write can land in the same cycle as the load event that the strobe machine issues. The bench provokes this directly by placing a write at the fourth edge after the strobe falls, and the random phase hits it often. Both directed and random cases are judged against a behavioural model. In that model, every load uses the register values and toggle mode that held before the edge.

// File: rtl/dtog_pkg.sv
package dtog_pkg;
    localparam int NCH      = 32;
    localparam int DW       = 14;
    localparam int AW       = $clog2(NCH);
    localparam int GW       = 8;
    localparam int NGRP     = NCH / GW;
    localparam int CTRL_LSB = 2;
    localparam logic [AW-1:0] CTRL_ADDR = AW'(12);

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_NONE = 2'b01,
        SEL_B    = 2'b10,
        SEL_A    = 2'b11
    } wsel_e;

    typedef enum logic [1:0] {L_IDLE, L_FIRE, L_HOLD} lstate_e;

    typedef enum logic [1:0] {PH_OFF, PH_ARMED, PH_SHOW_A, PH_SHOW_B} phase_e;
endpackage

// File: rtl/dtog_ldac_fsm.sv
module dtog_ldac_fsm
    import dtog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ldac_n,
    output logic ldac_evt
);
    logic s1_q, s2_q;
    lstate_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= ldac_n;
            s2_q <= s1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= L_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            L_IDLE: if (!s2_q) st_d = L_FIRE;
            L_FIRE: st_d = s2_q ? L_IDLE : L_HOLD;
            L_HOLD: if (s2_q) st_d = L_IDLE;
            default: st_d = L_IDLE;
        endcase
    end

    always_comb ldac_evt = (st_q == L_FIRE);

    // R6: a single strobe never yields back-to-back events
    a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        ldac_evt |=> !ldac_evt);
endmodule

// File: rtl/dtog_decode.sv
module dtog_decode
    import dtog_pkg::*;
(
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_addr,
    output logic          ctrl_we,
    output logic          a_we,
    output logic          b_we
);
    always_comb begin
        ctrl_we = 1'b0;
        a_we    = 1'b0;
        b_we    = 1'b0;
        if (wr_en) begin
            unique case (wsel_e'(wr_sel))
                SEL_CTRL: ctrl_we = (wr_addr == CTRL_ADDR);
                SEL_A:    a_we    = 1'b1;
                SEL_B:    b_we    = 1'b1;
                SEL_NONE: ;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/dtog_group.sv
module dtog_group
    import dtog_pkg::*;
#(
    parameter int G_W  = 8,
    parameter int D_W  = 14,
    localparam int LW  = (G_W > 1) ? $clog2(G_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ldac_evt,
    input  logic             en_cur,
    input  logic             en_nxt,
    input  logic             a_we,
    input  logic             b_we,
    input  logic [LW-1:0]    wsel,
    input  logic [D_W-1:0]   wdata,
    output logic [G_W*D_W-1:0] codes,
    output logic             flag_b
);
    phase_e st_q, st_d;
    logic   use_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!en_nxt) begin
            st_d = PH_OFF;
        end else begin
            unique case (st_q)
                PH_OFF:    st_d = PH_ARMED;
                PH_ARMED:  if (ldac_evt) st_d = PH_SHOW_A;
                PH_SHOW_A: if (ldac_evt) st_d = PH_SHOW_B;
                PH_SHOW_B: if (ldac_evt) st_d = PH_SHOW_A;
                default:   st_d = PH_OFF;
            endcase
        end
    end

    always_comb use_b = (st_q == PH_SHOW_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_b <= 1'b0;
        else if (ldac_evt) flag_b <= use_b;
    end

    for (genvar i = 0; i < G_W; i++) begin : g_ch
        logic [D_W-1:0] a_q, b_q, o_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_q <= '0;
                b_q <= '0;
                o_q <= '0;
            end else begin
                if (a_we && wsel == LW'(i))           a_q <= wdata;
                if (b_we && en_cur && wsel == LW'(i)) b_q <= wdata;
                if (ldac_evt)                         o_q <= use_b ? b_q : a_q;
            end
        end
        assign codes[i*D_W +: D_W] = o_q;
    end

    a_r6_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(codes) |-> $past(ldac_evt));
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_b) |-> $past(ldac_evt));
    a_r7_off_loads_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ldac_evt) && !$past(en_cur)) |-> !flag_b);
endmodule

// File: rtl/dtog_bank.sv
module dtog_bank
    import dtog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              ldac_n,
    output logic [NCH*DW-1:0] dac_code,
    output logic [NCH-1:0]    dac_sel_b
);
    localparam int LW = $clog2(GW);

    logic            ldac_evt;
    logic            ctrl_we, a_we, b_we;
    logic [NGRP-1:0] en_q, en_d;

    dtog_ldac_fsm u_ldac (
        .clk      (clk),
        .rst_n    (rst_n),
        .ldac_n   (ldac_n),
        .ldac_evt (ldac_evt)
    );

    dtog_decode u_dec (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_addr (wr_addr),
        .ctrl_we (ctrl_we),
        .a_we    (a_we),
        .b_we    (b_we)
    );

    always_comb en_d = ctrl_we ? wr_data[CTRL_LSB +: NGRP] : en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic hit;
        logic flag;
        assign hit = (wr_addr[AW-1:LW] == (AW-LW)'(g));

        dtog_group #(.G_W(GW), .D_W(DW)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .ldac_evt (ldac_evt),
            .en_cur   (en_q[g]),
            .en_nxt   (en_d[g]),
            .a_we     (a_we && hit),
            .b_we     (b_we && hit),
            .wsel     (wr_addr[LW-1:0]),
            .wdata    (wr_data),
            .codes    (dac_code[g*GW*DW +: GW*DW]),
            .flag_b   (flag)
        );
        assign dac_sel_b[g*GW +: GW] = {GW{flag}};
    end

    // R3: toggle enables move only on a control-register write
    a_r3_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> $past(wr_en && wr_sel == 2'b00 && wr_addr == CTRL_ADDR));
endmodule

// File: tb/tb_dtog_bank.sv
module tb_dtog_bank;
    localparam int NCH = 32;
    localparam int DW  = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = 2'b01;
    logic [4:0]        wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              ldac_n = 1'b1;
    logic [NCH*DW-1:0] dac_code;
    logic [NCH-1:0]    dac_sel_b;

    int checks = 0;
    int errors = 0;

    dtog_bank dut (.*);

    always #5 clk = ~clk;

    // behavioural reference
    int ma[NCH], mb[NCH], mo[NCH];
    int mflag[4], men[4], mph[4];  // mph: 0 off, 1 armed, 2 last A, 3 last B
    int hist[4];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin ma[i] = 0; mb[i] = 0; mo[i] = 0; end
            for (int g = 0; g < 4; g++) begin mflag[g] = 0; men[g] = 0; mph[g] = 0; end
            for (int k = 0; k < 4; k++) hist[k] = 1;
        end else begin
            automatic bit evt = (hist[2] == 0) && (hist[3] == 1);
            automatic int nen[4];
            for (int g = 0; g < 4; g++) nen[g] = men[g];
            if (wr_en && wr_sel == 2'b00 && wr_addr == 5'd12)
                for (int g = 0; g < 4; g++) nen[g] = wr_data[2+g];
            if (evt) begin
                for (int i = 0; i < NCH; i++)
                    mo[i] = (mph[i/8] == 2) ? mb[i] : ma[i];
                for (int g = 0; g < 4; g++) mflag[g] = (mph[g] == 2);
            end
            if (wr_en && wr_sel == 2'b11) ma[wr_addr] = wr_data;
            if (wr_en && wr_sel == 2'b10 && men[wr_addr/8] != 0) mb[wr_addr] = wr_data;
            for (int g = 0; g < 4; g++) begin
                if (nen[g] == 0)       mph[g] = 0;
                else if (mph[g] == 0)  mph[g] = 1;
                else if (evt)          mph[g] = (mph[g] == 2) ? 3 : 2;
                men[g] = nen[g];
            end
            for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = ldac_n;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            checks++;
            if (int'(dac_code[i*DW +: DW]) != mo[i] || int'(dac_sel_b[i]) != mflag[i/8]) begin
                errors++;
                $display("FAIL R1 R5 R6 R7 R9 model ch%0d: code=%0d flag=%0d expected code=%0d flag=%0d",
                         i, dac_code[i*DW +: DW], dac_sel_b[i], mo[i], mflag[i/8]);
            end
        end
    end

    task automatic chk(string tag, int ch, int exp_code, int exp_flag);
        checks++;
        if (int'(dac_code[ch*DW +: DW]) != exp_code || int'(dac_sel_b[ch]) != exp_flag) begin
            errors++;
            $display("FAIL %s ch%0d: code=%0d flag=%0d expected code=%0d flag=%0d",
                     tag, ch, dac_code[ch*DW +: DW], dac_sel_b[ch], exp_code, exp_flag);
        end
    endtask

    task automatic wr(input logic [1:0] s, input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_addr = 5'(a); wr_data = 14'(d);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b01;
    endtask

    task automatic strobe(input int len);
        @(negedge clk);
        ldac_n = 1'b0;
        repeat (len) @(negedge clk);
        ldac_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // write presented at the edge where the output loads (R9)
    task automatic strobe_with_write(input logic [1:0] s, input int a, input int d);
        @(negedge clk);
        ldac_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_addr = 5'(a); wr_data = 14'(d);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b01; ldac_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 0, 0, 0);
        chk("R1", 31, 0, 0);

        wr(2'b11, 3, 100);        // R2
        wr(2'b10, 3, 555);        // R4: disabled, ignored
        strobe(1);
        chk("R2 R7", 3, 100, 0);
        wr(2'b00, 12, 14'h04);    // R3 group 0 enable
        wr(2'b10, 3, 200);
        strobe(1);
        chk("R5 first A", 3, 100, 0);
        strobe(1);
        chk("R5 B", 3, 200, 1);
        strobe(1);
        chk("R5 A", 3, 100, 0);
        strobe(1);
        chk("R5 B again", 3, 200, 1);
        wr(2'b00, 12, 0);
        chk("R6 no change without strobe", 3, 200, 1);
        strobe(1);
        chk("R7 return to A", 3, 100, 0);

        wr(2'b10, 9, 777);        // R4 ignored in group 1
        wr(2'b11, 9, 50);
        wr(2'b00, 12, 14'h08);
        strobe(1);
        chk("R4", 9, 50, 0);
        strobe(1);
        chk("R4 B untouched", 9, 0, 1);

        wr(2'b01, 9, 999);        // R8
        wr(2'b00, 5, 14'h3C);     // R8: not the control address
        wr(2'b10, 9, 321);        // group 1 still enabled
        strobe(1);
        chk("R8", 9, 50, 0);
        strobe(1);
        chk("R8 B", 9, 321, 1);
        chk("R8 group0 off", 3, 100, 0);

        strobe(20);               // R6 long pulse: one step only
        chk("R6 long pulse", 9, 50, 0);

        strobe_with_write(2'b11, 9, 60);
        chk("R9 old B loaded", 9, 321, 1);
        strobe(1);
        chk("R9 new A later", 9, 60, 0);
        strobe_with_write(2'b00, 12, 0);
        chk("R9 old mode used", 9, 321, 1);
        strobe(1);
        chk("R9 then A", 9, 60, 0);

        // random phase compared by the model every cycle
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 2) == 0);
            wr_sel = 2'($urandom_range(0, 3));
            wr_addr = ($urandom_range(0, 3) == 0) ? 5'd12 : 5'($urandom_range(0, 31));
            wr_data = 14'($urandom);
            if ($urandom_range(0, 6) == 0) ldac_n = ~ldac_n;
        end
        @(negedge clk);
        wr_en = 1'b0; ldac_n = 1'b1;
        repeat (8) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule